// File: doc/BRIEF.md
# Event Routing Channel Array

This block routes single-cycle event signals from a wide bank of event generator lines to a set of event consumers. Each of twelve channels picks one generator line and conditions it. On the two clocked paths the channel turns chosen edges of that line into one-cycle event pulses. On the asynchronous path the line's level goes straight through. Software can also inject a one-cycle event on any channel.

Each consumer has its own multiplexer that picks which channel it listens to. A consumer that has received a clocked event keeps its channel busy until it returns an acknowledge. A new event on a busy channel raises an overrun flag. Overrun flags and event-detected flags feed a single interrupt line, gated by an enable word that has separate set and clear addresses.

A simple register port configures the block. Writes take effect on the clock edge where `reg_we` is high. Read data is registered and shows the word at `reg_addr` one clock edge later.

Top module: `evr_top`

## Requirements
- R1: A channel word is at byte address 0x40+4n. Bits 6:0 select the generator line, bits 9:8 select the path and bits 11:10 select the edge. The word reads back as written, with the unused bits at zero. A user multiplexer word is at 0x80+4u, with a 5-bit channel field in bits 4:0.
- R2: Synchronous path (path 0): edge select 0 gives no event, 1 gives the rising edge, 2 gives the falling edge and 3 gives both edges. A generator change set up before clock edge k gives a one-cycle event after edge k+1.
- R3: Resynchronized path (path 1): the same edge selection applies, with one extra synchronizer stage. The event appears after edge k+2.
- R4: Asynchronous path (path 2) passes the generator level to the consumer combinationally and ignores edge select. Path 3 forwards no generator activity.
- R5: Writing 1 to bit n of the software event word (0x10) produces a one-cycle event on channel n in the cycle after the write edge, on any path.
- R6: User multiplexer value 0 forwards nothing. Value n in 1..12 forwards channel n-1. Values above 12 forward nothing.
- R7: A clocked event sent to a consumer makes that consumer pending until its `user_ack` is seen. The status word (0x14, read only) shows busy for channel n in bit 16+n. That bit is set while any consumer selecting the channel is pending. The word shows ready in bit n when at least one consumer selects the channel and none of them is pending.
- R8: The flag word (0x0C) sets bit n (overrun) when channel n produces a clocked event while it is busy. It sets bit 16+n (event detected) on every clocked event of channel n.
- R9: Writing 1 to a bit of the flag word clears that flag. Writing 0 leaves it unchanged.
- R10: Writing 1s at 0x08 sets interrupt enable bits, and writing 1s at 0x04 clears them. Both addresses read back the enable word, which uses the same bit layout as the flags. `irq` is high one edge after any flag and its enable bit are both set.
- R11: After `rst`, and after a write of 1 to bit 0 at address 0x00 (software reset), every register, flag, enable and pending bit is zero and no event is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| gen_in | input | 128 | Event generator lines |
| user_ack | input | 8 | Per-consumer acknowledge |
| user_evt | output | 8 | Per-consumer routed event |
| irq | output | 1 | Interrupt request |

## Verification
Routing is tested with a table that pairs each path with each edge setting and drives both a rising and a falling generator transition. Counting the output pulses separates a wrong edge polarity from a missing or doubled pulse. The cycle of the first pulse separates the synchronous path from the resynchronized one. The asynchronous path is tested with a level change and no clock edge, which shows it is combinational. Multiplexer selections of 0, an in-range value and an out-of-range value, driven together with a software event on every channel, show that each consumer follows only its own selection. An event held without acknowledge followed by a second event separates busy tracking from overrun flagging.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam int CFG_GEN_W = 7;
  localparam int HI_LSB    = 16;
  localparam int DATA_W    = 32;

  localparam int A_CTRL    = 'h00;
  localparam int A_IEN_CLR = 'h04;
  localparam int A_IEN_SET = 'h08;
  localparam int A_FLAGS   = 'h0C;
  localparam int A_SWEVT   = 'h10;
  localparam int A_STATUS  = 'h14;
  localparam int A_CH_BASE = 'h40;
  localparam int A_US_BASE = 'h80;

  typedef enum logic [1:0] {
    PATH_SYNC   = 2'd0,
    PATH_RESYNC = 2'd1,
    PATH_ASYNC  = 2'd2,
    PATH_RSVD   = 2'd3
  } path_e;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_e;

  typedef struct packed {
    trig_e                trig;
    path_e                path;
    logic                 pad;
    logic [CFG_GEN_W-1:0] gen;
  } ch_cfg_t;

  localparam int CFG_W = $bits(ch_cfg_t);
endpackage

// File: rtl/evr_channel.sv
module evr_channel
  import evr_pkg::*;
#(
  parameter int NUM_GEN = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_GEN-1:0] gen_in,
  input  ch_cfg_t            cfg,
  input  logic               sw_pulse,
  output logic               evt_out,
  output logic               clk_evt
);
  localparam int GW = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1;

  logic raw, s1, s2, prev, det_in, hit, det_q, clocked;

  // generator line pick, out-of-range selections read as idle
  always_comb begin
    raw = 1'b0;
    if (int'(cfg.gen) < NUM_GEN) raw = gen_in[cfg.gen[GW-1:0]];
  end

  assign clocked = (cfg.path == PATH_SYNC) || (cfg.path == PATH_RESYNC);
  assign det_in  = (cfg.path == PATH_RESYNC) ? s2 : s1;

  always_comb begin
    case (cfg.trig)
      TRIG_RISE: hit = det_in & ~prev;
      TRIG_FALL: hit = ~det_in & prev;
      TRIG_BOTH: hit = det_in ^ prev;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      prev  <= 1'b0;
      det_q <= 1'b0;
    end else begin
      s1    <= raw;
      s2    <= s1;
      prev  <= det_in;
      det_q <= clocked & hit;
    end
  end

  assign clk_evt = det_q | sw_pulse;
  assign evt_out = (cfg.path == PATH_ASYNC) ? (raw | sw_pulse) : clk_evt;
endmodule

// File: rtl/evr_user_mux.sv
module evr_user_mux #(
  parameter int NUM_CH = 12,
  parameter int SEL_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel,
  input  logic [NUM_CH-1:0] ch_evt,
  input  logic [NUM_CH-1:0] ch_clk_evt,
  input  logic              ack,
  output logic              evt,
  output logic              fwd_clk,
  output logic              pend_q
);
  always_comb begin
    evt     = 1'b0;
    fwd_clk = 1'b0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (sel == SEL_W'(n + 1)) begin
        evt     = ch_evt[n];
        fwd_clk = ch_clk_evt[n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          pend_q <= 1'b0;
    else if (fwd_clk) pend_q <= 1'b1;
    else if (ack)     pend_q <= 1'b0;
  end
endmodule

// File: rtl/evr_regs.sv
module evr_regs
  import evr_pkg::*;
#(
  parameter int NUM_CH   = 12,
  parameter int NUM_USER = 8,
  parameter int ADDR_W   = 8,
  parameter int SEL_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] ch_clk_evt,
  input  logic [NUM_CH-1:0] busy,
  input  logic [NUM_CH-1:0] usr_rdy,
  output ch_cfg_t           cfg_q [NUM_CH],
  output logic [SEL_W-1:0]  sel_q [NUM_USER],
  output logic [NUM_CH-1:0] sw_pulse,
  output logic              soft_rst,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic [NUM_CH-1:0] ovr_flag,
  output logic [NUM_CH-1:0] evd_flag,
  output logic [NUM_CH-1:0] ien_ovr,
  output logic [NUM_CH-1:0] ien_evd
);
  localparam int HI_MSB = HI_LSB + NUM_CH - 1;

  logic                 sr;
  logic                 wr_set, wr_clr, wr_flags, wr_sw;
  logic [NUM_CH-1:0]    w_lo, w_hi;
  logic [DATA_W-1:0]    rd_word;

  function automatic logic [DATA_W-1:0] pack_pair(input logic [NUM_CH-1:0] lo,
                                                  input logic [NUM_CH-1:0] hi);
    logic [DATA_W-1:0] w;
    w = '0;
    w[NUM_CH-1:0]       = lo;
    w[HI_MSB:HI_LSB]    = hi;
    return w;
  endfunction

  assign soft_rst = we && (addr == ADDR_W'(A_CTRL)) && wdata[0];
  assign sr       = rst | soft_rst;
  assign wr_set   = we && (addr == ADDR_W'(A_IEN_SET));
  assign wr_clr   = we && (addr == ADDR_W'(A_IEN_CLR));
  assign wr_flags = we && (addr == ADDR_W'(A_FLAGS));
  assign wr_sw    = we && (addr == ADDR_W'(A_SWEVT));
  assign w_lo     = wdata[NUM_CH-1:0];
  assign w_hi     = wdata[HI_MSB:HI_LSB];

  // per-channel configuration words
  for (genvar n = 0; n < NUM_CH; n++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (sr) cfg_q[n] <= '0;
      else if (we && addr == ADDR_W'(A_CH_BASE + 4 * n)) begin
        cfg_q[n]     <= ch_cfg_t'(wdata[CFG_W-1:0]);
        cfg_q[n].pad <= 1'b0;
      end
    end
  end

  // per-consumer channel selections
  for (genvar u = 0; u < NUM_USER; u++) begin : g_sel
    always_ff @(posedge clk) begin
      if (sr) sel_q[u] <= '0;
      else if (we && addr == ADDR_W'(A_US_BASE + 4 * u)) sel_q[u] <= wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (sr) begin
      sw_pulse <= '0;
      ien_ovr  <= '0;
      ien_evd  <= '0;
      ovr_flag <= '0;
      evd_flag <= '0;
      irq      <= 1'b0;
    end else begin
      sw_pulse <= wr_sw ? w_lo : '0;
      if (wr_set) begin
        ien_ovr <= ien_ovr | w_lo;
        ien_evd <= ien_evd | w_hi;
      end else if (wr_clr) begin
        ien_ovr <= ien_ovr & ~w_lo;
        ien_evd <= ien_evd & ~w_hi;
      end
      ovr_flag <= (ovr_flag & ~(wr_flags ? w_lo : '0)) | (ch_clk_evt & busy);
      evd_flag <= (evd_flag & ~(wr_flags ? w_hi : '0)) | ch_clk_evt;
      irq      <= |(ovr_flag & ien_ovr) | |(evd_flag & ien_evd);
    end
  end

  always_comb begin
    rd_word = '0;
    if (addr == ADDR_W'(A_IEN_CLR) || addr == ADDR_W'(A_IEN_SET))
      rd_word = pack_pair(ien_ovr, ien_evd);
    else if (addr == ADDR_W'(A_FLAGS))
      rd_word = pack_pair(ovr_flag, evd_flag);
    else if (addr == ADDR_W'(A_STATUS))
      rd_word = pack_pair(usr_rdy, busy);
    for (int n = 0; n < NUM_CH; n++)
      if (addr == ADDR_W'(A_CH_BASE + 4 * n)) rd_word = DATA_W'(cfg_q[n]);
    for (int u = 0; u < NUM_USER; u++)
      if (addr == ADDR_W'(A_US_BASE + 4 * u)) rd_word = DATA_W'(sel_q[u]);
  end

  always_ff @(posedge clk) begin
    if (sr) rdata <= '0;
    else    rdata <= rd_word;
  end
endmodule

// File: rtl/evr_top.sv
module evr_top
  import evr_pkg::*;
#(
  parameter int NUM_CH   = 12,
  parameter int NUM_GEN  = 128,
  parameter int NUM_USER = 8,
  parameter int ADDR_W   = 8,
  parameter int SEL_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_GEN-1:0]  gen_in,
  input  logic [NUM_USER-1:0] user_ack,
  output logic [NUM_USER-1:0] user_evt,
  output logic                irq
);
  ch_cfg_t                    cfg_q [NUM_CH];
  logic [SEL_W-1:0]           sel_q [NUM_USER];
  logic [NUM_USER*SEL_W-1:0]  sel_flat;
  logic [NUM_CH-1:0]          sw_pulse, ch_evt, ch_clk_evt, busy, linked, usr_rdy;
  logic [NUM_CH-1:0]          ovr_flag, evd_flag, ien_ovr, ien_evd;
  logic [NUM_USER-1:0]        u_pend, u_clk;
  logic                       soft_rst, any_rst;

  assign any_rst = rst | soft_rst;

  evr_regs #(
    .NUM_CH(NUM_CH), .NUM_USER(NUM_USER), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) i_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .ch_clk_evt(ch_clk_evt), .busy(busy), .usr_rdy(usr_rdy),
    .cfg_q(cfg_q), .sel_q(sel_q), .sw_pulse(sw_pulse), .soft_rst(soft_rst),
    .rdata(reg_rdata), .irq(irq), .ovr_flag(ovr_flag), .evd_flag(evd_flag),
    .ien_ovr(ien_ovr), .ien_evd(ien_evd)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    evr_channel #(.NUM_GEN(NUM_GEN)) i_ch (
      .clk(clk), .rst(any_rst), .gen_in(gen_in), .cfg(cfg_q[n]),
      .sw_pulse(sw_pulse[n]), .evt_out(ch_evt[n]), .clk_evt(ch_clk_evt[n])
    );
  end

  for (genvar u = 0; u < NUM_USER; u++) begin : g_user
    assign sel_flat[u*SEL_W +: SEL_W] = sel_q[u];
    evr_user_mux #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) i_um (
      .clk(clk), .rst(any_rst), .sel(sel_q[u]), .ch_evt(ch_evt),
      .ch_clk_evt(ch_clk_evt), .ack(user_ack[u]), .evt(user_evt[u]),
      .fwd_clk(u_clk[u]), .pend_q(u_pend[u])
    );
  end

  // a channel is busy while any consumer that selects it is still pending
  always_comb begin
    busy   = '0;
    linked = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      for (int u = 0; u < NUM_USER; u++) begin
        if (sel_q[u] == SEL_W'(n + 1)) begin
          linked[n] = 1'b1;
          if (u_pend[u]) busy[n] = 1'b1;
        end
      end
    end
  end

  assign usr_rdy = linked & ~busy;
endmodule

// File: rtl/evr_checker.sv
module evr_checker #(
  parameter int NUM_CH   = 12,
  parameter int NUM_USER = 8,
  parameter int SEL_W    = 5
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      soft_rst,
  input logic                      irq,
  input logic [NUM_CH-1:0]         ovr_flag,
  input logic [NUM_CH-1:0]         evd_flag,
  input logic [NUM_CH-1:0]         ien_ovr,
  input logic [NUM_CH-1:0]         ien_evd,
  input logic [NUM_CH-1:0]         busy,
  input logic [NUM_USER*SEL_W-1:0] sel_flat,
  input logic [NUM_USER-1:0]       user_evt,
  input logic [NUM_USER-1:0]       user_ack,
  input logic [NUM_USER-1:0]       u_clk,
  input logic [NUM_USER-1:0]       u_pend
);
  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (ien_ovr == '0 && ien_evd == '0 && ovr_flag == '0 && evd_flag == '0 && u_pend == '0)); // R11

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (ien_ovr == '0 && ien_evd == '0) |=> !irq); // R10

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk_ch
    AST_OVR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
      (ovr_flag[n] && !$past(ovr_flag[n])) |-> $past(busy[n])); // R8
  end

  for (genvar u = 0; u < NUM_USER; u++) begin : g_chk_us
    AST_NOSEL_SILENT: assert property (@(posedge clk) disable iff (rst)
      (sel_flat[u*SEL_W +: SEL_W] == '0) |-> !user_evt[u]); // R6
    AST_EVT_SETS_PEND: assert property (@(posedge clk) disable iff (rst || soft_rst)
      u_clk[u] |=> u_pend[u]); // R7
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
      (user_ack[u] && !u_clk[u]) |=> !u_pend[u]); // R7
  end
endmodule

bind evr_top evr_checker #(.NUM_CH(NUM_CH), .NUM_USER(NUM_USER), .SEL_W(SEL_W)) i_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .irq(irq), .ovr_flag(ovr_flag),
  .evd_flag(evd_flag), .ien_ovr(ien_ovr), .ien_evd(ien_evd), .busy(busy),
  .sel_flat(sel_flat), .user_evt(user_evt), .user_ack(user_ack),
  .u_clk(u_clk), .u_pend(u_pend)
);

// File: tb/test_evr_top.sv
module test_evr_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_we = 1'b0;
  logic [7:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [127:0] gen_in = '0;
  logic [7:0]   user_ack = '0;
  logic [7:0]   user_evt;
  logic         irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  evr_top i_evr_top (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gen_in(gen_in),
    .user_ack(user_ack), .user_evt(user_evt), .irq(irq)
  );

  // {path[8:7], edge[6:5], from[4], to[3], expect_pulse[2], delay[1:0]}
  localparam logic [8:0] VEC [12] = '{
    {2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 2'd2},
    {2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0},
    {2'd0, 2'd2, 1'b1, 1'b0, 1'b1, 2'd2},
    {2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 2'd0},
    {2'd0, 2'd3, 1'b0, 1'b1, 1'b1, 2'd2},
    {2'd0, 2'd3, 1'b1, 1'b0, 1'b1, 2'd2},
    {2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0},
    {2'd1, 2'd1, 1'b0, 1'b1, 1'b1, 2'd3},
    {2'd1, 2'd2, 1'b1, 1'b0, 1'b1, 2'd3},
    {2'd1, 2'd3, 1'b1, 1'b0, 1'b1, 2'd3},
    {2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0},
    {2'd3, 2'd1, 1'b0, 1'b1, 1'b0, 2'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic ack_all();
    @(negedge clk);
    user_ack = '1;
    @(negedge clk);
    user_ack = '0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int cnt, first;
    logic [1:0] p;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    rd(8'h0C, rv); chk("R11 flags after reset", rv, 32'h0);
    rd(8'h08, rv); chk("R11 enable after reset", rv, 32'h0);
    rd(8'h14, rv); chk("R11 status after reset", rv, 32'h0);
    chk("R11 outputs after reset", {23'd0, irq, user_evt}, 32'h0);

    // route channel 0 to consumer 0
    wr(8'h80, 32'd1);
    wr(8'h40, 32'h0000_0405);
    rd(8'h40, rv); chk("R1 channel word readback", rv, 32'h0000_0405);

    // table of path / edge / transition vectors on channel 0, generator 5
    for (int v = 0; v < 12; v++) begin
      p = VEC[v][8:7];
      wr(8'h40, {20'd0, VEC[v][6:5], VEC[v][8:7], 8'h05});
      gen_in[5] = VEC[v][4];
      idle(5);
      ack_all();
      @(negedge clk);
      gen_in[5] = VEC[v][3];
      cnt = 0; first = 0;
      for (int i = 1; i <= 6; i++) begin
        @(posedge clk); @(negedge clk);
        if (user_evt[0]) begin
          cnt++;
          if (first == 0) first = i;
        end
      end
      chk(p == 2'd0 ? "R2 sync vector" : (p == 2'd1 ? "R3 resync vector" : "R4 reserved path vector"),
          {cnt[15:0], first[15:0]},
          {15'd0, VEC[v][2], 14'd0, VEC[v][1:0]});
      ack_all();
    end

    // R4 asynchronous path: level follows with no clock edge
    gen_in[5] = 1'b0;
    wr(8'h40, 32'h0000_0E05);
    idle(2);
    gen_in[5] = 1'b1; #1;
    chk("R4 async high", {31'd0, user_evt[0]}, 32'd1);
    gen_in[5] = 1'b0; #1;
    chk("R4 async low", {31'd0, user_evt[0]}, 32'd0);

    // R5 software event, one cycle long
    wr(8'h40, 32'h0000_0005);
    idle(3);
    wr(8'h0C, 32'h0FFF_0FFF);
    ack_all();
    wr(8'h10, 32'h0000_0001);
    chk("R5 sw event cycle", {31'd0, user_evt[0]}, 32'd1);
    @(negedge clk);
    chk("R5 sw event ends", {31'd0, user_evt[0]}, 32'd0);

    // R7 busy without ack, ready cleared
    idle(1);
    rd(8'h14, rv); chk("R7 busy status", rv, 32'h0001_0000);
    // R8 second event while busy -> overrun plus detect
    wr(8'h10, 32'h0000_0001);
    idle(2);
    rd(8'h0C, rv); chk("R8 overrun and detect flags", rv, 32'h0001_0001);
    ack_all();
    rd(8'h14, rv); chk("R7 ready after ack", rv, 32'h0000_0001);

    // R10 enable set / clear and irq
    wr(8'h08, 32'h0000_0001);
    idle(1);
    chk("R10 irq on enabled flag", {31'd0, irq}, 32'd1);
    rd(8'h04, rv); chk("R10 enable readback at clear address", rv, 32'h0000_0001);
    wr(8'h04, 32'h0000_0001);
    idle(1);
    chk("R10 irq after enable clear", {31'd0, irq}, 32'd0);

    // R9 write-one-to-clear, zero bits untouched
    wr(8'h0C, 32'h0000_0001);
    rd(8'h0C, rv); chk("R9 partial clear", rv, 32'h0001_0000);
    wr(8'h0C, 32'h0001_0000);
    rd(8'h0C, rv); chk("R9 full clear", rv, 32'h0);

    // R6 consumer selection: user1 -> channel 2, user0 -> channel 0, user2 none
    wr(8'h84, 32'd3);
    wr(8'h48, 32'h0000_0407);
    idle(4);
    ack_all();
    @(negedge clk);
    gen_in[7] = 1'b1;
    cnt = 0; first = 0;
    for (int i = 1; i <= 5; i++) begin
      @(posedge clk); @(negedge clk);
      if (user_evt[1]) cnt++;
      if (user_evt[0] || user_evt[2]) first++;
    end
    chk("R6 selected channel routed", {cnt[15:0], first[15:0]}, {16'd1, 16'd0});
    wr(8'h84, 32'd13);
    ack_all();
    wr(8'h10, 32'h0000_0FFF);
    chk("R6 out-of-range and zero select silent", {24'd0, user_evt}, 32'h0000_0001);

    // R11 software reset clears configuration
    ack_all();
    wr(8'h00, 32'h0000_0001);
    rd(8'h48, rv); chk("R11 soft reset channel word", rv, 32'h0);
    rd(8'h80, rv); chk("R11 soft reset selection", rv, 32'h0);
    rd(8'h0C, rv); chk("R11 soft reset flags", rv, 32'h0);

    summary();
  end
endmodule